// File: doc/BRIEF.md
# Programmable Watchdog Timer with Strobe

The block counts down a programmable interval on a 32 Hz tick and signals a timeout if software fails to service it in time. A single 8-bit control word, written and read over a plain synchronous register bus, holds three things. The first is a 6-bit timeout in units of one tick period (31.25 ms), so 1 gives 31.25 ms and 63 gives just under 2 s. The second is a write-only restart bit. The third is a guard bit that protects the timeout field, so software can restart the count without disturbing the interval.

The tick arrives as a one-cycle enable pulse in the system clock domain. A newly written interval does not reach the counter at once. It is held in a shadow copy and moved into the live counter on the next tick. On expiry the block sets a sticky flag, emits a one-cycle interrupt request if the enable input allows it, and reloads itself so that timeouts repeat. The flag is cleared by a pulse from a neighbouring flags register. The register bus carries single control words, not a data stream, so it has no valid/ready handshake: a write strobe is accepted in the cycle it is seen, and read data follows one cycle after the read strobe.

Top module: `wdog_tick_timer`

## Requirements
- R1: The control word has the guard bit at bit 7, the restart bit at bit 6 and the timeout at bits 5:0. A read strobe returns {guard, 0, timeout} on reg_rdata in the following cycle.
- R2: While the live timeout is 0 the block never sets the flag or raises the interrupt, however many ticks arrive.
- R3: With a live timeout N loaded, the flag rises on the Nth tick after the tick that loaded it, and only ever on a tick.
- R4: A write with bit 6 = 1 reloads the counter with the live timeout one cycle after the write. That reload wins over a tick in the same cycle, and the tick is then not counted. Bit 6 always reads back as 0, and a write with bit 6 = 0 does not restart the count.
- R5: A write while the stored guard bit is 1 leaves the timeout field unchanged. Bit 7 of every write updates the stored guard bit, so a write with bit 7 = 0 enables timeout updates from the next write on.
- R6: A newly written timeout becomes live only on the next tick. That tick loads the counter and does not decrement it.
- R7: Every expiry sets wd_flag. wd_irq pulses high for one cycle on expiry only when irq_en was 1.
- R8: wd_flag stays set until flag_clr is pulsed. An expiry in the same cycle as flag_clr leaves the flag set.
- R9: Expiry reloads the counter with the live timeout, so without a restart the flag rises again every N ticks.
- R10: After reset the timeout is 0, the guard bit is 1, wd_flag and wd_irq are 0, and reg_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32hz | input | 1 | One-cycle enable pulse at 32 Hz |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data: guard, restart, timeout |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| irq_en | input | 1 | Allows expiry to raise wd_irq |
| flag_clr | input | 1 | Clears the sticky timeout flag |
| wd_flag | output | 1 | Sticky timeout flag |
| wd_irq | output | 1 | One-cycle interrupt request on expiry |

## Verification
Two pairs of events can fall in the same cycle. In the first, a restart takes effect on the same edge as a tick while the counter stands at 1. The bench drives the tick in the cycle right after the restart write. It judges the result by whether the flag stays low and then needs a full interval of three further ticks. In the second, an expiry lands on the same edge as flag_clr. The bench drives both together when the counter is at 1 and expects the flag to stay set afterwards.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // What the counter does on a given edge, in priority order.
  typedef enum logic [2:0] {
    ACT_IDLE   = 3'd0,
    ACT_LOAD   = 3'd1,
    ACT_RELOAD = 3'd2,
    ACT_DEC    = 3'd3,
    ACT_EXPIRE = 3'd4
  } wdog_act_e;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs #(
  parameter int DATA_W = 8,
  parameter int TMO_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [TMO_W-1:0]  shadow_tmo,
  output logic              mask_q,
  output logic              strobe_req,
  output logic              load_req
);

  localparam int GUARD_BIT = DATA_W - 1;
  localparam int RSTRT_BIT = DATA_W - 2;

  logic              tmo_wr_ok;
  logic [DATA_W-1:0] rd_word;

  // Timeout may change only if the guard was already clear before this write.
  assign tmo_wr_ok = reg_wr && !mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q     <= 1'b1;
      shadow_tmo <= '0;
    end else if (reg_wr) begin
      mask_q <= reg_wdata[GUARD_BIT];
      if (tmo_wr_ok) shadow_tmo <= reg_wdata[TMO_W-1:0];
    end
  end

  // Restart request lives exactly one cycle after the write.
  always_ff @(posedge clk) begin
    if (!rst_n) strobe_req <= 1'b0;
    else        strobe_req <= reg_wr && reg_wdata[RSTRT_BIT];
  end

  // Pending transfer of the shadow timeout; a write on the same edge as
  // a tick keeps it pending so the newest value loads on the next tick.
  always_ff @(posedge clk) begin
    if (!rst_n)         load_req <= 1'b0;
    else if (tmo_wr_ok) load_req <= 1'b1;
    else if (tick)      load_req <= 1'b0;
  end

  always_comb begin
    rd_word                = '0;
    rd_word[GUARD_BIT]     = mask_q;
    rd_word[TMO_W-1:0]     = shadow_tmo;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_word;
  end

endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int TMO_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_req,
  input  logic             strobe_req,
  input  logic [TMO_W-1:0] shadow_tmo,
  output logic [TMO_W-1:0] act_tmo,
  output logic             expire
);

  localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

  logic [TMO_W-1:0] cnt_q;
  wdog_act_e        act;

  always_comb begin
    act = ACT_IDLE;
    if (tick && load_req)              act = ACT_LOAD;
    else if (strobe_req)               act = ACT_RELOAD;
    else if (tick && act_tmo != '0) begin
      if (cnt_q <= ONE)                act = ACT_EXPIRE;
      else                             act = ACT_DEC;
    end
  end

  assign expire = (act == ACT_EXPIRE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_tmo <= '0;
      cnt_q   <= '0;
    end else begin
      case (act)
        ACT_LOAD: begin
          act_tmo <= shadow_tmo;
          cnt_q   <= shadow_tmo;
        end
        ACT_RELOAD: cnt_q <= act_tmo;
        ACT_EXPIRE: cnt_q <= act_tmo;
        ACT_DEC:    cnt_q <= cnt_q - ONE;
        default:    cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/wdog_status.sv
module wdog_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic irq_en,
  input  logic flag_clr,
  output logic wd_flag,
  output logic wd_irq
);

  // Setting outranks clearing so no expiry is ever lost.
  always_ff @(posedge clk) begin
    if (!rst_n)        wd_flag <= 1'b0;
    else if (expire)   wd_flag <= 1'b1;
    else if (flag_clr) wd_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wd_irq <= 1'b0;
    else        wd_irq <= expire && irq_en;
  end

endmodule

// File: rtl/wdog_tick_timer.sv
module wdog_tick_timer #(
  parameter int DATA_W = 8,
  parameter int TMO_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32hz,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              irq_en,
  input  logic              flag_clr,
  output logic              wd_flag,
  output logic              wd_irq
);

  logic [TMO_W-1:0] shadow_tmo;
  logic [TMO_W-1:0] act_tmo;
  logic             mask_q;
  logic             strobe_req;
  logic             load_req;
  logic             expire;

  wdog_regs #(.DATA_W(DATA_W), .TMO_W(TMO_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_32hz),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .shadow_tmo (shadow_tmo),
    .mask_q     (mask_q),
    .strobe_req (strobe_req),
    .load_req   (load_req)
  );

  wdog_count #(.TMO_W(TMO_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_32hz),
    .load_req   (load_req),
    .strobe_req (strobe_req),
    .shadow_tmo (shadow_tmo),
    .act_tmo    (act_tmo),
    .expire     (expire)
  );

  wdog_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire   (expire),
    .irq_en   (irq_en),
    .flag_clr (flag_clr),
    .wd_flag  (wd_flag),
    .wd_irq   (wd_irq)
  );

endmodule

// File: rtl/wdog_tick_timer_chk.sv
module wdog_tick_timer_chk #(
  parameter int TMO_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_32hz,
  input logic             reg_wr,
  input logic             irq_en,
  input logic             flag_clr,
  input logic             wd_flag,
  input logic             wd_irq,
  input logic [TMO_W-1:0] act_tmo,
  input logic [TMO_W-1:0] shadow_tmo,
  input logic             mask_q,
  input logic             strobe_req
);

  assert_flag_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_flag) |-> $past(tick_32hz));

  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_flag) |-> $past(act_tmo) != '0);

  assert_strobe_selfclear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_req && !reg_wr |=> !strobe_req);

  assert_mask_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && mask_q |=> $stable(shadow_tmo));

  assert_new_tmo_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_tmo) |-> $past(tick_32hz));

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_irq |-> $past(irq_en) && wd_flag);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_flag && !flag_clr |=> wd_flag);

endmodule

bind wdog_tick_timer wdog_tick_timer_chk #(.TMO_W(TMO_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_32hz  (tick_32hz),
  .reg_wr     (reg_wr),
  .irq_en     (irq_en),
  .flag_clr   (flag_clr),
  .wd_flag    (wd_flag),
  .wd_irq     (wd_irq),
  .act_tmo    (act_tmo),
  .shadow_tmo (shadow_tmo),
  .mask_q     (mask_q),
  .strobe_req (strobe_req)
);

// File: tb/sim_wdog_tick_timer.sv
`timescale 1ns/1ps
module sim_wdog_tick_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32hz = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_en = 1'b0;
  logic       flag_clr = 1'b0;
  logic       wd_flag;
  logic       wd_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_tick_timer u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_32hz (tick_32hz),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_en    (irq_en),
    .flag_clr  (flag_clr),
    .wd_flag   (wd_flag),
    .wd_irq    (wd_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_32hz = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    flag_clr = 1'b0; irq_en = 1'b0; reg_wdata = 8'h00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_32hz = 1'b1;
      @(negedge clk);
      tick_32hz = 1'b0;
    end
  endtask

  task automatic clr_flag();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  // Clears guard, writes timeout with guard set again, then loads it with one tick.
  task automatic program_tmo(input logic [5:0] t);
    wr(8'h00);
    wr({2'b10, t});
    tick(1);
  endtask

  task automatic t_reset_and_mask();
    logic [7:0] d;
    do_reset();
    chk("R10 rdata after reset", reg_rdata, 8'h00);
    chk("R10 flag after reset", {7'd0, wd_flag}, 8'h00);
    chk("R10 irq after reset", {7'd0, wd_irq}, 8'h00);
    rd(d); chk("R10 R1 reset word", d, 8'h80);
    wr(8'h85); rd(d); chk("R5 guarded write", d, 8'h80);
    wr(8'h05); rd(d); chk("R5 guard clear only", d, 8'h00);
    wr(8'h45); rd(d); chk("R4 R1 restart reads zero", d, 8'h05);
    wr(8'h8A); rd(d); chk("R5 write then guard", d, 8'h8A);
    wr(8'h81); rd(d); chk("R5 guard holds", d, 8'h8A);
  endtask

  task automatic t_disabled();
    do_reset();
    tick(100);
    chk("R2 no expiry at zero", {7'd0, wd_flag}, 8'h00);
    program_tmo(6'd1);
    wr(8'h00); wr(8'h80);
    tick(1);
    tick(50);
    chk("R2 disabled after rewrite", {7'd0, wd_flag}, 8'h00);
  endtask

  task automatic t_interval();
    do_reset();
    wr(8'h00); wr(8'h03);
    tick(3);
    chk("R6 load tick not counted", {7'd0, wd_flag}, 8'h00);
    tick(1);
    chk("R3 expiry on Nth tick", {7'd0, wd_flag}, 8'h01);
    chk("R7 no irq when disabled", {7'd0, wd_irq}, 8'h00);
    clr_flag();
    chk("R8 clear pulse", {7'd0, wd_flag}, 8'h00);
    tick(2);
    chk("R9 not yet repeated", {7'd0, wd_flag}, 8'h00);
    tick(1);
    chk("R9 periodic expiry", {7'd0, wd_flag}, 8'h01);
  endtask

  task automatic t_irq();
    do_reset();
    irq_en = 1'b1;
    program_tmo(6'd2);
    tick(2);
    chk("R7 flag set", {7'd0, wd_flag}, 8'h01);
    chk("R7 irq pulse", {7'd0, wd_irq}, 8'h01);
    @(negedge clk);
    chk("R7 irq one cycle", {7'd0, wd_irq}, 8'h00);
    chk("R8 flag sticky", {7'd0, wd_flag}, 8'h01);
  endtask

  task automatic t_strobe();
    do_reset();
    program_tmo(6'd3);
    tick(2);
    wr(8'h80);
    tick(1);
    chk("R4 zero restart no effect", {7'd0, wd_flag}, 8'h01);
    clr_flag();
    tick(2);
    wr(8'hC0);
    tick(2);
    chk("R4 restart extends", {7'd0, wd_flag}, 8'h00);
    tick(1);
    chk("R4 expiry after restart", {7'd0, wd_flag}, 8'h01);
  endtask

  task automatic t_strobe_vs_tick();
    do_reset();
    program_tmo(6'd3);
    tick(2);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = 8'hC0;
    @(negedge clk);
    reg_wr = 1'b0; tick_32hz = 1'b1;
    @(negedge clk);
    tick_32hz = 1'b0;
    chk("R4 restart beats tick", {7'd0, wd_flag}, 8'h00);
    tick(2);
    chk("R4 tick not counted", {7'd0, wd_flag}, 8'h00);
    tick(1);
    chk("R4 full interval", {7'd0, wd_flag}, 8'h01);
  endtask

  task automatic t_clear_vs_expiry();
    do_reset();
    program_tmo(6'd2);
    tick(2);
    tick(1);
    @(negedge clk);
    tick_32hz = 1'b1; flag_clr = 1'b1;
    @(negedge clk);
    tick_32hz = 1'b0; flag_clr = 1'b0;
    chk("R8 expiry beats clear", {7'd0, wd_flag}, 8'h01);
    clr_flag();
    chk("R8 clear alone", {7'd0, wd_flag}, 8'h00);
  endtask

  task automatic t_max();
    do_reset();
    program_tmo(6'h3F);
    tick(62);
    chk("R3 max not yet", {7'd0, wd_flag}, 8'h00);
    tick(1);
    chk("R3 max expiry", {7'd0, wd_flag}, 8'h01);
  endtask

  initial begin
    t_reset_and_mask();
    t_disabled();
    t_interval();
    t_irq();
    t_strobe();
    t_strobe_vs_tick();
    t_clear_vs_expiry();
    t_max();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule